// File: doc/BRIEF.md
# Serial Layered Min-Sum Check Unit

This block runs the check-node step of a layered LDPC decoder for one parity-check row at a time, in serial form. Edges of the row arrive one per cycle on a valid/ready stream. Each edge carries the soft value held for its column and the check message that the same edge wrote in the previous iteration. The unit removes the old message from the soft value and keeps that intermediate value in a small row buffer. While the edges arrive it also tracks the two smallest magnitudes, where the smallest one sits, and the parity of all signs.

When the last edge of the row has been taken, the unit switches to emission and produces one result per cycle, in the same edge order. Each result holds the new normalized min-sum check message, which is written back in place of the old one, and the refreshed soft value for the next layer. The row degree comes from a register that can be reloaded between codes, so the same unit serves any row length up to a parameter limit. The caller supplies zero as the old message for every edge in the first iteration. Edge memories and their addressing sit outside this block.

Top module: `msu_check_row`

## Requirements
- R1: For each accepted edge the intermediate value is in_soft minus in_msg, both two's complement, saturated to the symmetric range -31..+31 (LLR_W=6).
- R2: The output message magnitude for edge k, before scaling, is the smallest intermediate magnitude among all other edges of the row. When two edges share the smallest magnitude, each of them receives that value.
- R3: The output message is negative exactly when an odd number of the other edges of the row have a negative intermediate value. A zero value counts as positive.
- R4: The magnitude m is scaled to m - floor(m/4), then clipped to 15, so out_msg always lies in -15..+15.
- R5: out_soft equals the edge's intermediate value plus its new message, saturated to -31..+31.
- R6: A pulse on cfg_load stores cfg_deg as the row degree, clamped to the range 2..MAX_DEG. A row uses the degree held when its first edge is accepted, so a load during a row takes effect from the next row.
- R7: In_ready is high while edges are being collected and low during emission. The result for edge 0 appears in the cycle right after the last edge is accepted. Results follow in consecutive cycles with out_idx counting 0..deg-1, and out_last is set on the final result only.
- R8: After reset, out_valid is low, in_ready is high and the row degree is DEF_DEG (4).
- R9: An edge accepted with in_first high starts a new row as edge 0, and any partly collected row is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Load strobe for the row-degree register |
| cfg_deg | input | 5 | New row degree (clamped to 2..MAX_DEG) |
| in_valid | input | 1 | Edge data valid |
| in_ready | output | 1 | Unit accepts an edge this cycle |
| in_first | input | 1 | Accepted edge starts a new row |
| in_soft | input | 6 | Soft value of the edge's column, two's complement |
| in_msg | input | 5 | Check message stored for this edge last iteration |
| out_valid | output | 1 | Result valid |
| out_last | output | 1 | Result belongs to the row's final edge |
| out_idx | output | 4 | Position of the edge within the row |
| out_soft | output | 6 | Refreshed soft value for the next layer |
| out_msg | output | 5 | New check message to write back |

## Verification
No result exists until a whole row has been taken in. The first result appears in the cycle right after the clock edge that accepts the last edge, and the others follow one per cycle, so a row of degree d gives its results during the d cycles after its final input. The bench drives every input on the falling edge. On each falling edge of the emission window it checks the result whose index equals the number of cycles since that final input, and it checks that the window closes in the cycle after out_last. Rows sweep every degree from 2 to 16 with random, tied, zero and saturating values, and include a degree reload during a row and a restart in the middle of a row.

// File: rtl/msu_pkg.sv
// Shared types for the serial min-sum check unit.
// Assumes nothing beyond the two operating phases of one row.
package msu_pkg;

    // Row phase: taking edges in, or sending results out
    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_EMIT    = 1'b1
    } msu_state_e;

endpackage

// File: rtl/msu_edge_buf.sv
// Row buffer holding the intermediate value of every edge of the current row.
// Written during collection, read by index during emission. Assumes one write
// per cycle at most and an index below DEPTH. Contents need no reset.
module msu_edge_buf #(
    parameter int W     = 6,
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] mem [DEPTH];

    // One storage word per edge slot, each with its own write decode
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) mem[g] <= wr_data;
        end
    end

    // Asynchronous read of the selected slot
    always_comb rd_data = mem[rd_idx];

endmodule

// File: rtl/msu_min_track.sv
// First-pass tracker: keeps the smallest and second smallest magnitude seen in
// the row, the index of the smallest, and the XOR of all signs. Assumes that
// magnitudes fit MAG_W bits. A restart marks the current edge as the row's first,
// so that edge is folded into cleared state.
module msu_min_track #(
    parameter int MAG_W = 5,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             restart,
    input  logic [MAG_W-1:0] mag,
    input  logic             sgn,
    input  logic [IDX_W-1:0] idx,
    output logic [MAG_W-1:0] min1,
    output logic [MAG_W-1:0] min2,
    output logic [IDX_W-1:0] min_idx,
    output logic             parity
);

    localparam logic [MAG_W-1:0] MAG_TOP = '1;

    logic [MAG_W-1:0] b_min1, b_min2;
    logic [IDX_W-1:0] b_idx;
    logic             b_par;

    // Starting point for this edge: cleared on restart, else the running state
    always_comb begin
        b_min1 = restart ? MAG_TOP : min1;
        b_min2 = restart ? MAG_TOP : min2;
        b_idx  = restart ? '0      : min_idx;
        b_par  = restart ? 1'b0    : parity;
    end

    // Fold one edge into the running minima and sign parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min1    <= MAG_TOP;
            min2    <= MAG_TOP;
            min_idx <= '0;
            parity  <= 1'b0;
        end else if (upd) begin
            parity <= b_par ^ sgn;
            if (mag < b_min1) begin
                min2    <= b_min1;
                min1    <= mag;
                min_idx <= idx;
            end else begin
                min1    <= b_min1;
                min_idx <= b_idx;
                min2    <= (mag < b_min2) ? mag : b_min2;
            end
        end
    end

endmodule

// File: rtl/msu_emit.sv
// Second-pass datapath, purely combinational: picks the excluded-minimum for
// the edge, scales it by 3/4 (m - m>>2), clips to the message range, applies
// the excluded sign, and adds the message back onto the intermediate value with
// symmetric saturation. Assumes LLR_W >= MSG_W and MAG_W = LLR_W-1.
module msu_emit #(
    parameter int LLR_W = 6,
    parameter int MSG_W = 5,
    parameter int MAG_W = 5,
    parameter int IDX_W = 4
) (
    input  logic [LLR_W-1:0] q,
    input  logic [IDX_W-1:0] idx,
    input  logic [MAG_W-1:0] min1,
    input  logic [MAG_W-1:0] min2,
    input  logic [IDX_W-1:0] min_idx,
    input  logic             parity,
    output logic [MSG_W-1:0] new_msg,
    output logic [LLR_W-1:0] new_soft
);

    localparam int MSG_MAX = (1 << (MSG_W - 1)) - 1;
    localparam int SAT_MAX = (1 << (LLR_W - 1)) - 1;
    localparam logic signed [LLR_W:0] S_HI = (LLR_W + 1)'(SAT_MAX);
    localparam logic signed [LLR_W:0] S_LO = -S_HI;

    logic [MAG_W-1:0]        mag_sel, scaled, clipped;
    logic                    neg;
    logic signed [MSG_W-1:0] r;
    logic signed [LLR_W:0]   sum;

    // Excluded minimum, normalization and clip
    always_comb begin
        mag_sel = (idx == min_idx) ? min2 : min1;
        scaled  = mag_sel - (mag_sel >> 2);
        clipped = (scaled > MAG_W'(MSG_MAX)) ? MAG_W'(MSG_MAX) : scaled;
    end

    // Excluded sign applied to the clipped magnitude
    always_comb begin
        neg     = parity ^ q[LLR_W-1];
        r       = neg ? -$signed(MSG_W'(clipped)) : $signed(MSG_W'(clipped));
        new_msg = r;
    end

    // Soft value for the next layer, saturated symmetrically
    always_comb begin
        sum = $signed({q[LLR_W-1], q}) + (LLR_W + 1)'(r);
        if (sum > S_HI)      new_soft = S_HI[LLR_W-1:0];
        else if (sum < S_LO) new_soft = S_LO[LLR_W-1:0];
        else                 new_soft = sum[LLR_W-1:0];
    end

endmodule

// File: rtl/msu_check_row.sv
// Serial layered min-sum check unit (top). Collects one row of edges, forming
// soft minus old message per edge, then emits a new normalized message and an
// updated soft value per edge in arrival order. Assumes old messages are in
// -16..15 and that the caller keeps edges in row order. The row degree comes
// from a reloadable register and is latched when a row starts.
module msu_check_row #(
    parameter int LLR_W   = 6,
    parameter int MSG_W   = 5,
    parameter int MAX_DEG = 16,
    parameter int DEF_DEG = 4,
    localparam int DEG_W  = $clog2(MAX_DEG + 1),
    localparam int IDX_W  = $clog2(MAX_DEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [DEG_W-1:0] cfg_deg,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_first,
    input  logic [LLR_W-1:0] in_soft,
    input  logic [MSG_W-1:0] in_msg,
    output logic             out_valid,
    output logic             out_last,
    output logic [IDX_W-1:0] out_idx,
    output logic [LLR_W-1:0] out_soft,
    output logic [MSG_W-1:0] out_msg
);
    import msu_pkg::*;

    localparam int MAG_W   = LLR_W - 1;
    localparam int SAT_MAX = (1 << (LLR_W - 1)) - 1;
    localparam logic signed [LLR_W:0] Q_HI = (LLR_W + 1)'(SAT_MAX);
    localparam logic signed [LLR_W:0] Q_LO = -Q_HI;
    localparam logic [DEG_W-1:0] DEG_MIN = DEG_W'(2);
    localparam logic [DEG_W-1:0] DEG_TOP = DEG_W'(MAX_DEG);

    msu_state_e       state;
    logic [DEG_W-1:0] deg_reg, row_deg, cnt, cur_deg, widx_ext;
    logic [IDX_W-1:0] emit_idx, widx;
    logic             accept, restart, last_in, emit_end;

    logic signed [LLR_W:0] q_wide;
    logic [LLR_W-1:0]      q_sat, q_rd;
    logic [MAG_W-1:0]      q_mag, min1, min2;
    logic [IDX_W-1:0]      min_idx;
    logic                  parity;

    // Handshake and row bookkeeping for the incoming edge
    always_comb begin
        in_ready = (state == ST_COLLECT);
        accept   = in_valid && in_ready;
        restart  = accept && (in_first || (cnt == '0));
        widx_ext = restart ? '0 : cnt;
        widx     = widx_ext[IDX_W-1:0];
        cur_deg  = restart ? deg_reg : row_deg;
        last_in  = accept && (DEG_W'(widx_ext + DEG_W'(1)) == cur_deg);
        emit_end = (state == ST_EMIT) && (DEG_W'(emit_idx) == DEG_W'(row_deg - DEG_W'(1)));
    end

    // Intermediate value: soft minus old message, saturated, and its magnitude
    always_comb begin
        q_wide = $signed({in_soft[LLR_W-1], in_soft})
               - $signed({{(LLR_W + 1 - MSG_W){in_msg[MSG_W-1]}}, in_msg});
        if (q_wide > Q_HI)      q_sat = Q_HI[LLR_W-1:0];
        else if (q_wide < Q_LO) q_sat = Q_LO[LLR_W-1:0];
        else                    q_sat = q_wide[LLR_W-1:0];
        q_mag = q_sat[LLR_W-1] ? MAG_W'(-q_sat) : q_sat[MAG_W-1:0];
    end

    // Degree register, clamped to the supported range on load
    always_ff @(posedge clk) begin
        if (!rst_n)                 deg_reg <= DEG_W'(DEF_DEG);
        else if (cfg_load) begin
            if (cfg_deg < DEG_MIN)      deg_reg <= DEG_MIN;
            else if (cfg_deg > DEG_TOP) deg_reg <= DEG_TOP;
            else                        deg_reg <= cfg_deg;
        end
    end

    // Phase control: edge count, latched row degree and emission index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_COLLECT;
            cnt      <= '0;
            row_deg  <= DEG_W'(DEF_DEG);
            emit_idx <= '0;
        end else begin
            if (restart) row_deg <= deg_reg;
            if (last_in) begin
                state    <= ST_EMIT;
                cnt      <= '0;
                emit_idx <= '0;
            end else if (accept) begin
                cnt <= DEG_W'(widx_ext + DEG_W'(1));
            end
            if (state == ST_EMIT) begin
                emit_idx <= IDX_W'(emit_idx + IDX_W'(1));
                if (emit_end) state <= ST_COLLECT;
            end
        end
    end

    msu_edge_buf #(.W(LLR_W), .DEPTH(MAX_DEG), .IDX_W(IDX_W)) buf_i (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (widx),
        .wr_data (q_sat),
        .rd_idx  (emit_idx),
        .rd_data (q_rd)
    );

    msu_min_track #(.MAG_W(MAG_W), .IDX_W(IDX_W)) trk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (accept),
        .restart (restart),
        .mag     (q_mag),
        .sgn     (q_sat[LLR_W-1]),
        .idx     (widx),
        .min1    (min1),
        .min2    (min2),
        .min_idx (min_idx),
        .parity  (parity)
    );

    msu_emit #(.LLR_W(LLR_W), .MSG_W(MSG_W), .MAG_W(MAG_W), .IDX_W(IDX_W)) emit_i (
        .q        (q_rd),
        .idx      (emit_idx),
        .min1     (min1),
        .min2     (min2),
        .min_idx  (min_idx),
        .parity   (parity),
        .new_msg  (out_msg),
        .new_soft (out_soft)
    );

    // Result stream markers
    always_comb begin
        out_valid = (state == ST_EMIT);
        out_last  = emit_end;
        out_idx   = emit_idx;
    end

endmodule

// File: rtl/msu_check_row_chk.sv
// Protocol and range checker for msu_check_row, attached with bind below.
// Observes ports only; assumes the default-style synchronous active-low reset.
module msu_check_row_chk #(
    parameter int LLR_W = 6,
    parameter int MSG_W = 5,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_last,
    input logic [IDX_W-1:0] out_idx,
    input logic [LLR_W-1:0] out_soft,
    input logic [MSG_W-1:0] out_msg
);

    localparam logic [MSG_W-1:0] MSG_NEG_END = {1'b1, {(MSG_W - 1){1'b0}}};
    localparam logic [LLR_W-1:0] LLR_NEG_END = {1'b1, {(LLR_W - 1){1'b0}}};

    // R7: no edge is taken while results are being sent
    p_ready_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R7: the emission window closes right after the final result
    p_last_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |=> !out_valid);

    // R7: results before the last are followed by the next index
    p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |=> out_valid && (out_idx == IDX_W'($past(out_idx) + 1'b1)));

    // R7: a window opens with edge 0
    p_idx_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_idx == '0));

    // R4: messages stay inside the symmetric clip range
    p_msg_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_msg != MSG_NEG_END));

    // R5: soft output never reaches the asymmetric negative end
    p_soft_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_soft != LLR_NEG_END));

    // R8: the cycle after reset shows an idle, ready unit
    p_reset_idle_r8: assert property (@(posedge clk)
        !$past(rst_n) |-> !out_valid && in_ready);

endmodule

bind msu_check_row msu_check_row_chk #(
    .LLR_W (LLR_W),
    .MSG_W (MSG_W),
    .IDX_W (IDX_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_idx   (out_idx),
    .out_soft  (out_soft),
    .out_msg   (out_msg)
);

// File: tb/msu_check_row_tb_top.sv
// Bench for msu_check_row: sweeps every row degree with random, tied, zero and
// saturating values, and computes expected results arithmetically per edge.
module msu_check_row_tb_top;

    localparam int LLR_W = 6;
    localparam int MSG_W = 5;
    localparam int MAX_DEG = 16;
    localparam int DEG_W = $clog2(MAX_DEG + 1);
    localparam int IDX_W = $clog2(MAX_DEG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [DEG_W-1:0] cfg_deg = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic in_first = 1'b0;
    logic [LLR_W-1:0] in_soft = '0;
    logic [MSG_W-1:0] in_msg = '0;
    logic out_valid, out_last;
    logic [IDX_W-1:0] out_idx;
    logic [LLR_W-1:0] out_soft;
    logic [MSG_W-1:0] out_msg;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    int soft_v [MAX_DEG];
    int msg_v  [MAX_DEG];
    int q_v    [MAX_DEG];
    int e_soft [MAX_DEG];
    int e_msg  [MAX_DEG];

    always #5 clk = ~clk;

    msu_check_row #(.LLR_W(LLR_W), .MSG_W(MSG_W), .MAX_DEG(MAX_DEG), .DEF_DEG(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_deg(cfg_deg),
        .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
        .in_soft(in_soft), .in_msg(in_msg), .out_valid(out_valid),
        .out_last(out_last), .out_idx(out_idx), .out_soft(out_soft), .out_msg(out_msg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat31(input int x);
        if (x > 31) return 31;
        if (x < -31) return -31;
        return x;
    endfunction

    // Expected results by direct exclusion over all other edges
    task automatic compute(input int deg);
        for (int k = 0; k < deg; k++) q_v[k] = sat31(soft_v[k] - msg_v[k]);
        for (int k = 0; k < deg; k++) begin
            int m = 1000;
            int neg = 0;
            int sc;
            int r;
            for (int j = 0; j < deg; j++) begin
                if (j != k) begin
                    int a = (q_v[j] < 0) ? -q_v[j] : q_v[j];
                    if (a < m) m = a;
                    if (q_v[j] < 0) neg ^= 1;
                end
            end
            sc = m - (m / 4);
            if (sc > 15) sc = 15;
            r = neg ? -sc : sc;
            e_msg[k]  = r;
            e_soft[k] = sat31(q_v[k] + r);
        end
    endtask

    task automatic fill_random(input int deg, input int mode);
        for (int k = 0; k < deg; k++) begin
            case (mode)
                0: begin soft_v[k] = $urandom_range(63) - 32; msg_v[k] = $urandom_range(31) - 16; end
                1: begin soft_v[k] = $urandom_range(6) - 3;   msg_v[k] = 0; end
                2: begin soft_v[k] = (k % 2) ? -32 : 31;      msg_v[k] = (k % 2) ? 15 : -16; end
                default: begin soft_v[k] = 0; msg_v[k] = 0; end
            endcase
        end
    endtask

    // Drive edges starting at a falling edge; returns at the falling edge after the last
    task automatic send_edges(input int deg, input bit first_flag, input int load_at, input int load_val);
        for (int k = 0; k < deg; k++) begin
            in_valid = 1'b1;
            in_first = first_flag && (k == 0);
            in_soft  = LLR_W'(soft_v[k]);
            in_msg   = MSG_W'(msg_v[k]);
            cfg_load = (k == load_at);
            cfg_deg  = DEG_W'(load_val);
            #1;
            chk(in_ready == 1'b1 && out_valid == 1'b0, "R7 ready during collect", int'(in_ready), 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_first = 1'b0;
        cfg_load = 1'b0;
    endtask

    // Check the emission window; entered at the falling edge after the last edge
    task automatic expect_results(input int deg, input string tag);
        for (int k = 0; k < deg; k++) begin
            chk(out_valid == 1'b1, {tag, " R7 valid"}, int'(out_valid), 1);
            chk(in_ready == 1'b0, "R7 ready low while emitting", int'(in_ready), 0);
            chk(int'(out_idx) == k, "R7 index", int'(out_idx), k);
            chk(out_last == (k == deg - 1), "R7 last marker", int'(out_last), int'(k == deg - 1));
            chk($signed(out_msg) == e_msg[k], {tag, " R2 R3 R4 message"}, $signed(out_msg), e_msg[k]);
            chk($signed(out_soft) == e_soft[k], {tag, " R1 R5 soft"}, $signed(out_soft), e_soft[k]);
            @(negedge clk);
        end
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R7 window closed", int'(out_valid), 0);
    endtask

    task automatic load_deg(input int v);
        cfg_load = 1'b1;
        cfg_deg  = DEG_W'(v);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic run_row(input int deg, input int mode, input string tag);
        fill_random(deg, mode);
        compute(deg);
        send_edges(deg, 1'b1, -1, 0);
        expect_results(deg, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: idle after reset
        chk(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);
        @(negedge clk);
        // R8: default degree of 4 without any load
        run_row(4, 0, "R8 default degree");

        // R2 R3 R4 R5: sweep all degrees with several value patterns
        for (int d = 2; d <= MAX_DEG; d++) begin
            load_deg(d);
            for (int rep = 0; rep < 4; rep++) run_row(d, 0, "sweep random");
            run_row(d, 1, "R2 ties and zeros");
            run_row(d, 2, "R1 R5 saturation");
            run_row(d, 3, "R3 all zero");
        end

        // R6: clamp below and above the range
        load_deg(1);
        run_row(2, 0, "R6 clamp low");
        load_deg(30);
        run_row(16, 0, "R6 clamp high");

        // R6: a load during a row waits for the next row
        load_deg(5);
        fill_random(5, 0);
        compute(5);
        send_edges(5, 1'b1, 2, 3);
        expect_results(5, "R6 load mid-row keeps degree");
        run_row(3, 0, "R6 new degree next row");

        // R9: restart in the middle of a partial row
        load_deg(4);
        fill_random(2, 0);
        send_edges(2, 1'b0, -1, 0);
        chk(out_valid == 1'b0, "R9 no output for partial row", int'(out_valid), 0);
        fill_random(4, 0);
        compute(4);
        send_edges(4, 1'b1, -1, 0);
        expect_results(4, "R9 restart");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule